// File: doc/BRIEF.md
# Buffered Dual-Compare PWM Channel

One channel of a timer block. It makes a pulse from a free-running counter value that a shared counter drives into it. Two compare slots are used. The leading slot (A) starts the pulse and the trailing slot (B) ends it. Placing the two values in the count range gives an edge-aligned pulse or a centred pulse.

Software writes each compare value into a shadow register. The shadow values move into the active compare registers only when the counter wraps, so a period never runs with one old value and one new value. An external hold input can freeze these transfers, so that several channels can be retimed together.

A prescaler enable pulse (`tick_i`) qualifies every counter observation. A wrap is seen when the counter value on an enabled clock is lower than its value on the previous enabled clock.

Precedence rules settle the cases where the two matches collide:
- The trailing match beats a simultaneous leading match.
- A leading match that comes after the trailing match in the same period is dropped.
- The masking is cleared at the wrap, so a leading value of 0 acts on the wrap clock itself.

A sticky flag records matches. The flag never gates the output. Force strobes let software move the output without a counter match.

The compare writes are plain strobes. They are never stalled, so there is no back-pressure. A write lands in the shadow register on the same clock.

Top module: `pwmc_channel`

## Requirements
- R1: After reset, `flag_o` is 0, all shadow and active compare values are 0, and the internal level is inactive. `pwm_o` therefore equals `pol_i`.
- R2: On a clock with `tick_i` high, a counter value equal to the effective A value makes the level active, and a value equal to the effective B value makes it inactive. With `tick_i` low, no match occurs. The output changes on the clock edge that samples the match.
- R3: When A and B match on the same enabled clock, the B result (inactive level) wins.
- R4: After a B match, further A matches in the same counter period are ignored: the level stays inactive and they do not set the flag.
- R5: A wrap clears the B masking of R4 for the new period. An A value of 0 matching on the wrap clock therefore makes the level active, even though B matched in the previous period.
- R6: On an enabled clock where a wrap is seen and `upd_hold_i` is low, both shadow values become active and are already used for the match on that same clock. When `upd_hold_i` is high at the wrap, the old active values are kept. Active values change at no other time.
- R7: With `flag_any_i` = 0, only a B match sets the flag. With `flag_any_i` = 1, an unmasked A match sets it as well.
- R8: The flag stays set until a `flag_clr_i` strobe clears it. A set and a clear on the same clock leave it set. Matches keep changing the output while the flag is set.
- R9: `frc_a_i` makes the level active and `frc_b_i` makes it inactive on the next edge, with B winning if both are given or if a B match occurs on that clock. Forces never set the flag and do not change the R4 masking.
- R10: `pwm_o` is the internal level XOR `pol_i`. With `pol_i` = 0 the active level is high; with `pol_i` = 1 every level is inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CNT_W | Shared counter value |
| tick_i | input | 1 | Prescaler enable; qualifies counter observation |
| a_wr_i | input | 1 | Write strobe for the A shadow value |
| a_val_i | input | CNT_W | Data for the A shadow value |
| b_wr_i | input | 1 | Write strobe for the B shadow value |
| b_val_i | input | CNT_W | Data for the B shadow value |
| flag_any_i | input | 1 | 0: flag on B only; 1: flag on A or B |
| pol_i | input | 1 | Output polarity |
| frc_a_i | input | 1 | Force the level an A match gives |
| frc_b_i | input | 1 | Force the level a B match gives |
| upd_hold_i | input | 1 | Blocks shadow-to-active transfer at a wrap |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the flag |
| pwm_o | output | 1 | Channel output |
| flag_o | output | 1 | Sticky match flag |

## Verification
The stimulus patterns each isolate one behaviour:
- A counter sweeping 0 to 9 on every clock, with A below B, shows the basic leading and trailing edges. Repeating the sweep with `tick_i` high only every other clock separates tick qualification from raw counter equality.
- Setting A above B, A equal to B, and A at 0 isolates, in turn, the in-period mask, same-clock precedence and the mask release at the wrap.
- Writing new shadow values mid-period, with hold low and then high, shows whether the transfer happens exactly at the wrap and whether the hold input blocks it.
- The same sweeps with each flag mode, with forces, with clears that collide with sets, and with polarity 1 separate the flag, force and polarity paths from the match path.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;
  localparam int NUM_SLOTS = 2;
  localparam int SLOT_A    = 0;
  localparam int SLOT_B    = 1;
endpackage

// File: rtl/pwmc_wrap_det.sv
module pwmc_wrap_det #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             wrap_o
);
  logic [CNT_W-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_q <= '0;
    else if (tick_i) last_q <= cnt_i;
  end

  assign wrap_o = tick_i && (cnt_i < last_q);
endmodule

// File: rtl/pwmc_cmp_slot.sv
module pwmc_cmp_slot #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             hit_o,
  output logic [CNT_W-1:0] act_o
);
  logic [CNT_W-1:0] shd_q, act_q, eff;

  // the value taking effect at a boundary is used on that boundary clock
  assign eff = load_i ? shd_q : act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= '0;
      act_q <= '0;
    end else begin
      if (wr_i)   shd_q <= val_i;
      if (load_i) act_q <= shd_q;
    end
  end

  assign hit_o = tick_i && (cnt_i == eff);
  assign act_o = act_q;
endmodule

// File: rtl/pwmc_out_ctl.sv
module pwmc_out_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic wrap_i,
  input  logic a_raw_i,
  input  logic b_raw_i,
  input  logic frc_a_i,
  input  logic frc_b_i,
  input  logic flag_any_i,
  input  logic flag_clr_i,
  output logic lvl_o,
  output logic flag_o,
  output logic a_hit_o,
  output logic b_done_o
);
  logic lvl_q, flag_q, bdone_q;
  logic mask_now, to_off, to_on, flag_set;

  // the mask from the previous period is void on the wrap clock
  assign mask_now = bdone_q && !wrap_i;
  assign a_hit_o  = a_raw_i && !mask_now;
  assign to_off   = b_raw_i || frc_b_i;
  assign to_on    = a_hit_o || frc_a_i;
  assign flag_set = b_raw_i || (flag_any_i && a_hit_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      flag_q  <= 1'b0;
      bdone_q <= 1'b0;
    end else begin
      if (to_off)     lvl_q <= 1'b0;
      else if (to_on) lvl_q <= 1'b1;

      if (flag_set)        flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;

      if (tick_i) bdone_q <= b_raw_i || mask_now;
    end
  end

  assign lvl_o    = lvl_q;
  assign flag_o   = flag_q;
  assign b_done_o = bdone_q;
endmodule

// File: rtl/pwmc_channel.sv
module pwmc_channel #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tick_i,
  input  logic             a_wr_i,
  input  logic [CNT_W-1:0] a_val_i,
  input  logic             b_wr_i,
  input  logic [CNT_W-1:0] b_val_i,
  input  logic             flag_any_i,
  input  logic             pol_i,
  input  logic             frc_a_i,
  input  logic             frc_b_i,
  input  logic             upd_hold_i,
  input  logic             flag_clr_i,
  output logic             pwm_o,
  output logic             flag_o
);
  import pwmc_pkg::*;

  logic                 wrap, load, lvl, b_done, a_hit;
  logic [NUM_SLOTS-1:0] slot_wr, slot_hit;
  logic [CNT_W-1:0]     slot_val [NUM_SLOTS];
  logic [CNT_W-1:0]     slot_act [NUM_SLOTS];
  logic [CNT_W-1:0]     a_act, b_act;

  assign slot_wr[SLOT_A]  = a_wr_i;
  assign slot_wr[SLOT_B]  = b_wr_i;
  assign slot_val[SLOT_A] = a_val_i;
  assign slot_val[SLOT_B] = b_val_i;

  pwmc_wrap_det #(.CNT_W(CNT_W)) u_wrap (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cnt_i(cnt_i), .wrap_o(wrap)
  );

  assign load = wrap && !upd_hold_i;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    pwmc_cmp_slot #(.CNT_W(CNT_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .wr_i(slot_wr[s]), .val_i(slot_val[s]),
      .load_i(load), .tick_i(tick_i), .cnt_i(cnt_i),
      .hit_o(slot_hit[s]), .act_o(slot_act[s])
    );
  end

  assign a_act = slot_act[SLOT_A];
  assign b_act = slot_act[SLOT_B];

  pwmc_out_ctl u_out (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wrap_i(wrap),
    .a_raw_i(slot_hit[SLOT_A]), .b_raw_i(slot_hit[SLOT_B]),
    .frc_a_i(frc_a_i), .frc_b_i(frc_b_i), .flag_any_i(flag_any_i),
    .flag_clr_i(flag_clr_i), .lvl_o(lvl), .flag_o(flag_o),
    .a_hit_o(a_hit), .b_done_o(b_done)
  );

  assign pwm_o = lvl ^ pol_i;
endmodule

// File: rtl/pwmc_channel_chk.sv
module pwmc_channel_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             flag_any_i,
  input logic             frc_a_i,
  input logic             frc_b_i,
  input logic             flag_clr_i,
  input logic             upd_hold_i,
  input logic             flag_o,
  input logic             lvl,
  input logic             wrap,
  input logic             a_hit,
  input logic             b_hit,
  input logic [CNT_W-1:0] a_act,
  input logic [CNT_W-1:0] b_act
);
  p_b_over_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    b_hit |=> !lvl);

  p_a_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_hit && !b_hit && !frc_b_i) |=> lvl);

  p_force_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frc_b_i |=> !lvl);

  p_force_noflag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !flag_o) |=> !flag_o);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flag_clr_i) |=> flag_o);

  p_mode0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_any_i && !b_hit && !flag_o) |=> !flag_o);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap || upd_hold_i) |=> ($stable(a_act) && $stable(b_act)));
endmodule

bind pwmc_channel pwmc_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .flag_any_i(flag_any_i),
  .frc_a_i(frc_a_i), .frc_b_i(frc_b_i), .flag_clr_i(flag_clr_i),
  .upd_hold_i(upd_hold_i), .flag_o(flag_o), .lvl(lvl), .wrap(wrap),
  .a_hit(a_hit), .b_hit(slot_hit[pwmc_pkg::SLOT_B]),
  .a_act(a_act), .b_act(b_act)
);

// File: tb/tb_pwmc_channel.sv
`timescale 1ns/1ps
module tb_pwmc_channel;
  localparam int W = 8;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] cnt_i = 0, a_val_i = 0, b_val_i = 0;
  logic tick_i = 0, a_wr_i = 0, b_wr_i = 0, flag_any_i = 0, pol_i = 0;
  logic frc_a_i = 0, frc_b_i = 0, upd_hold_i = 0, flag_clr_i = 0;
  logic pwm_o, flag_o;

  always #2.5 clk = ~clk;

  pwmc_channel #(.CNT_W(W)) dut (.*);

  int checks = 0, failures = 0;
  string cur_req = "R2";
  // reference model state
  int m_lvl = 0, m_flag = 0, m_prev = 0, m_ash = 0, m_bsh = 0;
  int m_aact = 0, m_bact = 0, m_bdone = 0;
  int cnt_model = 0;

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one clock: model the edge from current inputs, then compare after it
  task automatic step();
    int wrap, ea, eb, bd, ah, bh, ld;
    ah = 0; bh = 0;
    if (tick_i) begin
      wrap = (int'(cnt_i) < m_prev);
      ld   = wrap && !upd_hold_i;
      ea = ld ? m_ash : m_aact;
      eb = ld ? m_bsh : m_bact;
      bd = wrap ? 0 : m_bdone;
      ah = (int'(cnt_i) == ea) && !bd;
      bh = (int'(cnt_i) == eb);
      m_aact = ea; m_bact = eb;
      m_bdone = bh ? 1 : bd;
      m_prev = int'(cnt_i);
    end
    if (bh || frc_b_i) m_lvl = 0;
    else if (ah || frc_a_i) m_lvl = 1;
    if (bh || (flag_any_i && ah)) m_flag = 1;
    else if (flag_clr_i) m_flag = 0;
    if (a_wr_i) m_ash = int'(a_val_i);
    if (b_wr_i) m_bsh = int'(b_val_i);
    @(posedge clk); #1;
    check(cur_req, int'(pwm_o), m_lvl ^ int'(pol_i), "pwm_o");
    check(cur_req, int'(flag_o), m_flag, "flag_o");
    a_wr_i = 0; b_wr_i = 0; frc_a_i = 0; frc_b_i = 0; flag_clr_i = 0;
  endtask

  // counter sweep 0..top, advancing on ticks; tick every 'every' clocks
  task automatic run(int n, int top, int every);
    for (int i = 0; i < n; i++) begin
      tick_i = ((i % every) == 0);
      cnt_i = W'(cnt_model);
      step();
      if (tick_i) cnt_model = (cnt_model == top) ? 0 : cnt_model + 1;
    end
    tick_i = 0;
  endtask

  task automatic load_vals(int a, int b);
    a_val_i = W'(a); b_val_i = W'(b); a_wr_i = 1; b_wr_i = 1;
  endtask

  initial begin
    fork
      begin
        #4; rst_n = 0; #10;
        check("R1", int'(flag_o), 0, "flag after reset");
        check("R1", int'(pwm_o), 0, "pwm after reset pol0");
        pol_i = 1; #1;
        check("R1", int'(pwm_o), 1, "pwm after reset pol1 (R10)");
        pol_i = 0;
        @(negedge clk); rst_n = 1;
        // R2: A=4 B=6, basic pulse, active values load at wrap (R6)
        cur_req = "R2"; load_vals(4, 6); run(40, 9, 1);
        // R2: gapped ticks
        cur_req = "R2"; run(40, 9, 2);
        // R6: hold blocks transfer; then release
        cur_req = "R6"; upd_hold_i = 1; load_vals(2, 8); run(25, 9, 1);
        upd_hold_i = 0; run(25, 9, 1);
        // R3: A equals B
        cur_req = "R3"; load_vals(5, 5); run(25, 9, 1);
        // R4: A after B masked, with flag_any to show no flag
        cur_req = "R4"; flag_any_i = 1; flag_clr_i = 1; load_vals(7, 3); run(25, 9, 1);
        // R5: A=0 beats previous-period B
        cur_req = "R5"; flag_any_i = 0; load_vals(0, 6); run(25, 9, 1);
        cur_req = "R3"; load_vals(0, 0); run(25, 9, 1);
        // R7: mode 1 flag on A
        cur_req = "R7"; load_vals(3, 200); run(15, 9, 1);
        flag_clr_i = 1; step(); run(15, 9, 1);
        flag_any_i = 1; flag_clr_i = 1; run(25, 9, 1);
        // R8: clear colliding with set; output continues
        cur_req = "R8"; flag_any_i = 0; load_vals(2, 5); run(15, 9, 1);
        for (int i = 0; i < 20; i++) begin
          flag_clr_i = 1; tick_i = 1; cnt_i = W'(cnt_model); step();
          cnt_model = (cnt_model == 9) ? 0 : cnt_model + 1;
        end
        tick_i = 0;
        // R9: forces without ticks, no flag
        cur_req = "R9"; flag_clr_i = 1; step();
        frc_a_i = 1; step(); step();
        frc_b_i = 1; step();
        frc_a_i = 1; frc_b_i = 1; step();
        frc_a_i = 1; step(); step();
        // R10: inverted polarity run
        cur_req = "R10"; pol_i = 1; run(30, 9, 1);
        frc_b_i = 1; step();
        pol_i = 0; step();
      end
      begin
        repeat (20000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule